// File: doc/BRIEF.md
# Register-Pair File and Address Unit

This block holds the working registers of an 8-bit processor core: six general byte registers (B, C, D, E, H, L), an accumulator, a carry flag and a 16-bit stack pointer. The byte registers also act as three 16-bit pairs: BC, DE and HL, with B, D and H as the high halves. A decoder upstream presents one micro-operation at a time. The unit can write a single byte register, step a pair up or down, add a pair into HL, and swap HL with DE. It can also move data between registers and a byte-wide synchronous memory: HL as two bytes at a direct address, the accumulator through the address held in BC or DE, and any pair pushed to or popped from the stack.

Register-only operations finish on the edge that accepts them. Operations that touch memory run a short sequence of their own. While a sequence runs, `busy` is high and new commands are dropped. A one-cycle `done` pulse marks the end of every accepted command. The memory port has no handshake. Read data appears on `mem_rdata` in the cycle after the read address is presented.

Operation codes on `cmd_op`: 0 no-op, 1 byte write, 2 carry load, 3 stack-pointer load, 4 pair increment, 5 pair decrement, 6 pair add into HL, 7 HL/DE swap, 8 HL load direct, 9 HL store direct, 10 accumulator load indirect, 11 accumulator store indirect, 12 push, 13 pop. Codes 14 and 15 act as no-ops. Pair codes on `cmd_pair`: 0 BC, 1 DE, 2 HL, 3 SP, or for push and pop the accumulator plus a flag byte.

Top module: `regpair_addr_unit`

## Requirements
- R1: After a clock edge with `rst_n` low, all byte registers, the accumulator, SP and carry read zero, and `busy`, `done` and `mem_en` are low.
- R2: Op 1 writes `cmd_data` into the byte register chosen by `cmd_reg` (0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 7 accumulator), and code 6 changes nothing. Op 2 loads carry from `cmd_data[0]`. Op 3 loads SP from `cmd_addr`.
- R3: Ops 4 and 5 add or subtract one, modulo 2^16, on the pair chosen by `cmd_pair` (0 BC, 1 DE, 2 HL, 3 SP) and leave carry unchanged.
- R4: Op 6 writes HL plus the chosen pair, modulo 2^16, into HL and sets carry to bit 16 of the sum. The accumulator and the other pairs are left unchanged. For example, 1234h plus 5678h gives 68ACh.
- R5: Op 7 swaps the full contents of HL and DE in one step and leaves carry unchanged.
- R6: Op 8 loads L from `cmd_addr` and H from `cmd_addr`+1. Op 9 stores L at `cmd_addr` and H at `cmd_addr`+1. The address wraps from FFFFh to 0000h.
- R7: Ops 10 and 11 load or store the accumulator at the address held in BC when `cmd_pair[0]` is 0, or in DE when it is 1, using a single memory cycle.
- R8: Op 12 writes the high byte at SP-1, then the low byte at SP-2, and leaves SP two lower. With pair code 3 the high byte is the accumulator and the low byte is the carry in bit 0 with all other bits zero.
- R9: Op 13 reads the low byte from SP and the high byte from SP+1 into the pair, then raises SP by two. With pair code 3 the high byte goes to the accumulator and bit 0 of the low byte goes to carry.
- R10: Register-only commands update on the accepting edge, and `done` is high in the following cycle. A two-byte transfer drives memory in the two cycles after acceptance, commits one cycle later, and raises `done` in the next cycle, when `busy` is already low and a new command is accepted.
- R11: A command presented while `busy` is high is ignored and changes no register, SP or carry.
- R12: `mem_en` is high only in the memory cycles of a transfer, and `mem_we` is high only for stores and pushes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Operation code |
| cmd_pair | input | 2 | Pair selector |
| cmd_reg | input | 3 | Byte register selector for op 1 |
| cmd_data | input | 8 | Byte data for ops 1 and 2 |
| cmd_addr | input | 16 | Direct address for ops 3, 8 and 9 |
| busy | output | 1 | Memory sequence in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after the address |
| out_bc | output | 16 | BC pair |
| out_de | output | 16 | DE pair |
| out_hl | output | 16 | HL pair |
| out_acc | output | 8 | Accumulator |
| out_sp | output | 16 | Stack pointer |
| out_cy | output | 1 | Carry flag |

## Verification
Two functions can meet in the same cycle: the end of a memory sequence and the arrival of the next command. They collide in two ways. First, a byte write is presented while an HL load is still running, and the bench then checks that the accumulator kept its old value and HL took the loaded word. Second, a pair increment is presented in the very cycle `done` rises after a load, and the bench checks that the increment acts on the freshly loaded HL. A behavioural model in the bench tracks every register, the expected memory access of each cycle, `busy` and `done`, and is compared with the ports on every falling edge.

// File: rtl/regpair_pkg.sv
// Shared types and constants for the register-pair unit.
// Assumes byte-wide registers; a pair is two bytes and also the address width.
package regpair_pkg;

    localparam int BYTE_W = 8;
    localparam int PAIR_W = 2 * BYTE_W;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_WR8    = 4'd1,
        OP_SETCY  = 4'd2,
        OP_SETSP  = 4'd3,
        OP_INC    = 4'd4,
        OP_DEC    = 4'd5,
        OP_DADD   = 4'd6,
        OP_SWAP   = 4'd7,
        OP_LDHL   = 4'd8,
        OP_STHL   = 4'd9,
        OP_LDACC  = 4'd10,
        OP_STACC  = 4'd11,
        OP_PUSH   = 4'd12,
        OP_POP    = 4'd13,
        OP_RSV14  = 4'd14,
        OP_RSV15  = 4'd15
    } pair_op_e;

    localparam logic [1:0] PR_BC = 2'd0;
    localparam logic [1:0] PR_DE = 2'd1;
    localparam logic [1:0] PR_HL = 2'd2;
    localparam logic [1:0] PR_SP = 2'd3;

    typedef enum logic [1:0] {
        XS_IDLE,
        XS_FIRST,
        XS_SECOND,
        XS_FINISH
    } xfer_state_e;

endpackage

// File: rtl/rp_pair_arith.sv
// 16-bit pair arithmetic: step up, step down and add into HL.
// Purely combinational; the caller picks which result to write back.
module rp_pair_arith #(
    parameter int W = 16
) (
    input  logic [W-1:0] opnd,
    input  logic [W-1:0] hl,
    output logic [W-1:0] inc,
    output logic [W-1:0] dec,
    output logic [W:0]   sum
);

    // Wrapping increment and decrement of the selected pair
    assign inc = opnd + W'(1);
    assign dec = opnd - W'(1);

    // Double-width add with carry out in the top bit
    assign sum = {1'b0, hl} + {1'b0, opnd};

endmodule

// File: rtl/rp_xfer_seq.sv
// Memory transfer sequencer: runs one or two byte accesses on a
// single-port synchronous memory, then a finish cycle that commits.
// Assumes read data is valid in the cycle after the address, and that
// start only arrives while idle.
module rp_xfer_seq
    import regpair_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            two_byte,
    input  logic            is_write,
    input  logic [AW-1:0]   addr0,
    input  logic [AW-1:0]   addr1,
    input  logic [DW-1:0]   wdata0,
    input  logic [DW-1:0]   wdata1,
    input  logic [DW-1:0]   mem_rdata,
    output logic            busy,
    output logic            commit,
    output logic [2*DW-1:0] rd_word,
    output logic            mem_en,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata
);

    xfer_state_e   state;
    logic [AW-1:0] a0_q, a1_q;
    logic [DW-1:0] w0_q, w1_q, low_q;
    logic          two_q, wr_q;

    // Sequence state and captured request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= XS_IDLE;
            a0_q  <= '0;
            a1_q  <= '0;
            w0_q  <= '0;
            w1_q  <= '0;
            low_q <= '0;
            two_q <= 1'b0;
            wr_q  <= 1'b0;
        end else begin
            case (state)
                XS_IDLE: begin
                    if (start) begin
                        a0_q  <= addr0;
                        a1_q  <= addr1;
                        w0_q  <= wdata0;
                        w1_q  <= wdata1;
                        two_q <= two_byte;
                        wr_q  <= is_write;
                        state <= XS_FIRST;
                    end
                end
                XS_FIRST:  state <= two_q ? XS_SECOND : XS_FINISH;
                XS_SECOND: begin
                    low_q <= mem_rdata;
                    state <= XS_FINISH;
                end
                default:   state <= XS_IDLE;
            endcase
        end
    end

    // Memory port drive for the current byte cycle
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = a0_q;
        mem_wdata = w0_q;
        if (state == XS_FIRST) begin
            mem_en = 1'b1;
            mem_we = wr_q;
        end else if (state == XS_SECOND) begin
            mem_en    = 1'b1;
            mem_we    = wr_q;
            mem_addr  = a1_q;
            mem_wdata = w1_q;
        end
    end

    // Status and assembled read word (low byte first in address order)
    assign busy    = (state != XS_IDLE);
    assign commit  = (state == XS_FINISH);
    assign rd_word = two_q ? {mem_rdata, low_q} : {{DW{1'b0}}, mem_rdata};

    // The first memory cycle follows acceptance at the captured address
    assert_first_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (mem_en && mem_addr == $past(addr0) && mem_we == $past(is_write)));

    // A two-byte request reaches its second address in the next cycle
    assert_second_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && two_q && state == XS_FIRST) |=> (mem_en && mem_addr == a1_q));

    // The finish cycle is followed by idle with the port quiet
    assert_finish_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (!busy && !mem_en));

    // No new request may arrive while a sequence is running
    assert_start_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/regpair_addr_unit.sv
// Register-pair file and address unit. Holds B..L, the accumulator, carry
// and SP, executes pair arithmetic at once and memory moves through the
// transfer sequencer. Commands arriving while busy are dropped.
// Assumes the address width equals the pair width.
module regpair_addr_unit
    import regpair_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [3:0]      cmd_op,
    input  logic [1:0]      cmd_pair,
    input  logic [2:0]      cmd_reg,
    input  logic [DW-1:0]   cmd_data,
    input  logic [2*DW-1:0] cmd_addr,
    output logic            busy,
    output logic            done,
    output logic            mem_en,
    output logic            mem_we,
    output logic [2*DW-1:0] mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic [2*DW-1:0] out_bc,
    output logic [2*DW-1:0] out_de,
    output logic [2*DW-1:0] out_hl,
    output logic [DW-1:0]   out_acc,
    output logic [2*DW-1:0] out_sp,
    output logic            out_cy
);

    localparam int PW      = 2 * DW;
    localparam int NREG    = 8;
    localparam int ACC_IDX = 7;
    localparam int HOLE    = 6;

    logic [DW-1:0] rf [NREG];
    logic [PW-1:0] sp_q;
    logic          cy_q;
    logic          done_q;

    logic [PW-1:0] bc, de, hl;
    pair_op_e      op, op_q;
    logic [1:0]    pair_q;

    logic          accept, start, mem_op, two_byte, is_write;
    logic [PW-1:0] a0, a1, sel_pair, push_word, ind_addr;
    logic [DW-1:0] w0, w1;
    logic [PW-1:0] inc_v, dec_v;
    logic [PW:0]   sum_v;
    logic          x_busy, x_commit;
    logic [PW-1:0] x_rd;

    logic          pw_en, sw_en, b8_en, cy_en, sp_en;
    logic [1:0]    pw_sel;
    logic [PW-1:0] pw_val, sp_val;
    logic [2:0]    b8_idx;
    logic [DW-1:0] b8_val;
    logic          cy_val;

    assign bc     = {rf[0], rf[1]};
    assign de     = {rf[2], rf[3]};
    assign hl     = {rf[4], rf[5]};
    assign op     = pair_op_e'(cmd_op);
    assign accept = cmd_valid && !x_busy;
    assign start  = accept && mem_op;

    // Operand pair selection for arithmetic and push
    always_comb begin
        case (cmd_pair)
            PR_BC:   sel_pair = bc;
            PR_DE:   sel_pair = de;
            PR_HL:   sel_pair = hl;
            default: sel_pair = sp_q;
        endcase
    end

    assign push_word = (cmd_pair == PR_SP) ? {rf[ACC_IDX], {(DW-1){1'b0}}, cy_q} : sel_pair;
    assign ind_addr  = cmd_pair[0] ? de : bc;

    rp_pair_arith #(.W(PW)) u_arith (
        .opnd (sel_pair),
        .hl   (hl),
        .inc  (inc_v),
        .dec  (dec_v),
        .sum  (sum_v)
    );

    // Address and data plan of a memory command
    always_comb begin
        mem_op   = 1'b1;
        two_byte = 1'b1;
        is_write = 1'b0;
        a0       = cmd_addr;
        a1       = cmd_addr + PW'(1);
        w0       = '0;
        w1       = '0;
        case (op)
            OP_LDHL: ;
            OP_STHL: begin
                is_write = 1'b1;
                w0       = rf[5];
                w1       = rf[4];
            end
            OP_LDACC: begin
                two_byte = 1'b0;
                a0       = ind_addr;
            end
            OP_STACC: begin
                two_byte = 1'b0;
                is_write = 1'b1;
                a0       = ind_addr;
                w0       = rf[ACC_IDX];
            end
            OP_PUSH: begin
                is_write = 1'b1;
                a0       = sp_q - PW'(1);
                a1       = sp_q - PW'(2);
                w0       = push_word[PW-1:DW];
                w1       = push_word[DW-1:0];
            end
            OP_POP: begin
                a0 = sp_q;
                a1 = sp_q + PW'(1);
            end
            default: mem_op = 1'b0;
        endcase
    end

    rp_xfer_seq #(.DW(DW), .AW(PW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .two_byte  (two_byte),
        .is_write  (is_write),
        .addr0     (a0),
        .addr1     (a1),
        .wdata0    (w0),
        .wdata1    (w1),
        .mem_rdata (mem_rdata),
        .busy      (x_busy),
        .commit    (x_commit),
        .rd_word   (x_rd),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    // Remember which memory command is running for its commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_NOP;
            pair_q <= PR_BC;
        end else if (start) begin
            op_q   <= op;
            pair_q <= cmd_pair;
        end
    end

    // Write-back selection from immediate commands or a finished transfer
    always_comb begin
        pw_en  = 1'b0;
        pw_sel = PR_HL;
        pw_val = '0;
        sw_en  = 1'b0;
        b8_en  = 1'b0;
        b8_idx = 3'(ACC_IDX);
        b8_val = '0;
        cy_en  = 1'b0;
        cy_val = 1'b0;
        sp_en  = 1'b0;
        sp_val = '0;
        if (accept && !mem_op) begin
            case (op)
                OP_WR8: begin
                    b8_en  = (cmd_reg != 3'(HOLE));
                    b8_idx = cmd_reg;
                    b8_val = cmd_data;
                end
                OP_SETCY: begin
                    cy_en  = 1'b1;
                    cy_val = cmd_data[0];
                end
                OP_SETSP: begin
                    sp_en  = 1'b1;
                    sp_val = cmd_addr;
                end
                OP_INC: begin
                    pw_en  = 1'b1;
                    pw_sel = cmd_pair;
                    pw_val = inc_v;
                end
                OP_DEC: begin
                    pw_en  = 1'b1;
                    pw_sel = cmd_pair;
                    pw_val = dec_v;
                end
                OP_DADD: begin
                    pw_en  = 1'b1;
                    pw_val = sum_v[PW-1:0];
                    cy_en  = 1'b1;
                    cy_val = sum_v[PW];
                end
                OP_SWAP: sw_en = 1'b1;
                default: ;
            endcase
        end else if (x_commit) begin
            case (op_q)
                OP_LDHL: begin
                    pw_en  = 1'b1;
                    pw_val = x_rd;
                end
                OP_LDACC: begin
                    b8_en  = 1'b1;
                    b8_val = x_rd[DW-1:0];
                end
                OP_PUSH: begin
                    sp_en  = 1'b1;
                    sp_val = sp_q - PW'(2);
                end
                OP_POP: begin
                    sp_en  = 1'b1;
                    sp_val = sp_q + PW'(2);
                    if (pair_q == PR_SP) begin
                        b8_en  = 1'b1;
                        b8_val = x_rd[PW-1:DW];
                        cy_en  = 1'b1;
                        cy_val = x_rd[0];
                    end else begin
                        pw_en  = 1'b1;
                        pw_sel = pair_q;
                        pw_val = x_rd;
                    end
                end
                default: ;
            endcase
        end
    end

    // Register, SP, carry and done updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) rf[i] <= '0;
            sp_q   <= '0;
            cy_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= x_commit || (accept && !mem_op);
            if (pw_en) begin
                case (pw_sel)
                    PR_BC:   {rf[0], rf[1]} <= pw_val;
                    PR_DE:   {rf[2], rf[3]} <= pw_val;
                    PR_HL:   {rf[4], rf[5]} <= pw_val;
                    default: sp_q <= pw_val;
                endcase
            end
            if (sw_en) begin
                rf[2] <= rf[4];
                rf[3] <= rf[5];
                rf[4] <= rf[2];
                rf[5] <= rf[3];
            end
            if (b8_en) rf[b8_idx] <= b8_val;
            if (cy_en) cy_q <= cy_val;
            if (sp_en) sp_q <= sp_val;
        end
    end

    assign busy    = x_busy;
    assign done    = done_q;
    assign out_bc  = bc;
    assign out_de  = de;
    assign out_hl  = hl;
    assign out_acc = rf[ACC_IDX];
    assign out_sp  = sp_q;
    assign out_cy  = cy_q;

    // Increment of HL steps the whole pair and keeps carry
    assert_inc_hl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_INC && cmd_pair == PR_HL) |=>
            (hl == $past(hl) + PW'(1) && cy_q == $past(cy_q)));

    // Pair add leaves accumulator and DE alone
    assert_dadd_side_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_DADD && cmd_pair != PR_DE) |=>
            ($stable(de) && $stable(rf[ACC_IDX])));

    // Swap exchanges HL and DE without touching carry
    assert_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_SWAP) |=>
            (hl == $past(de) && de == $past(hl) && cy_q == $past(cy_q)));

    // Push ends with SP two lower
    assert_push_sp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (x_commit && op_q == OP_PUSH) |=> (sp_q == $past(sp_q) - PW'(2)));

    // Pop ends with SP two higher
    assert_pop_sp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (x_commit && op_q == OP_POP) |=> (sp_q == $past(sp_q) + PW'(2)));

    // A finished transfer is announced in the next cycle
    assert_done_after_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        x_commit |=> (done && !busy));

    // While a transfer is mid-way nothing visible changes
    assert_hold_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (x_busy && !x_commit) |=>
            ($stable(bc) && $stable(de) && $stable(hl) && $stable(rf[ACC_IDX])
             && $stable(sp_q) && $stable(cy_q)));

endmodule

// File: tb/regpair_addr_unit_tb.sv
module regpair_addr_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [1:0]  cmd_pair = '0;
    logic [2:0]  cmd_reg = '0;
    logic [7:0]  cmd_data = '0;
    logic [15:0] cmd_addr = '0;
    logic        busy, done, mem_en, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] out_bc, out_de, out_hl, out_sp;
    logic [7:0]  out_acc;
    logic        out_cy;

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    regpair_addr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_pair(cmd_pair), .cmd_reg(cmd_reg), .cmd_data(cmd_data),
        .cmd_addr(cmd_addr), .busy(busy), .done(done), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .out_bc(out_bc), .out_de(out_de),
        .out_hl(out_hl), .out_acc(out_acc), .out_sp(out_sp), .out_cy(out_cy)
    );

    function automatic logic [7:0] fill(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    // Memory seen by the design
    logic [7:0] mem [logic [15:0]];
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] = mem_wdata;
            else mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : fill(mem_addr);
        end
    end

    // Reference model state
    typedef struct { bit en; bit we; bit [15:0] addr; bit [7:0] wd; } mcyc_t;
    mcyc_t      exp_q [$];
    bit [7:0]   rmem [bit [15:0]];
    bit [7:0]   m_r [8];
    bit [7:0]   n_r [8];
    bit [15:0]  m_sp, n_sp;
    bit         m_cy, n_cy, m_done, started;
    int         m_cnt = 0;
    string      m_tag = "R1";

    function automatic bit [7:0] rref(input bit [15:0] a);
        return rmem.exists(a) ? rmem[a] : fill(a);
    endfunction

    function automatic bit [15:0] mpair(input bit [1:0] p);
        case (p)
            2'd0: return {m_r[0], m_r[1]};
            2'd1: return {m_r[2], m_r[3]};
            2'd2: return {m_r[4], m_r[5]};
            default: return m_sp;
        endcase
    endfunction

    task automatic npair(input bit [1:0] p, input bit [15:0] v);
        case (p)
            2'd0: begin n_r[0] = v[15:8]; n_r[1] = v[7:0]; end
            2'd1: begin n_r[2] = v[15:8]; n_r[3] = v[7:0]; end
            2'd2: begin n_r[4] = v[15:8]; n_r[5] = v[7:0]; end
            default: n_sp = v;
        endcase
    endtask

    task automatic mcyc(input bit we, input bit [15:0] a, input bit [7:0] d);
        mcyc_t e;
        e.en = 1'b1; e.we = we; e.addr = a; e.wd = d;
        exp_q.push_back(e);
        if (we) rmem[a] = d;
    endtask

    task automatic midle();
        mcyc_t e;
        e.en = 1'b0; e.we = 1'b0; e.addr = '0; e.wd = '0;
        exp_q.push_back(e);
    endtask

    task automatic model_accept();
        bit [16:0] s;
        bit [15:0] a, w;
        n_r = m_r; n_sp = m_sp; n_cy = m_cy;
        case (cmd_op)
            4'd1: begin m_tag = "R2"; if (cmd_reg != 3'd6) n_r[cmd_reg] = cmd_data; end
            4'd2: begin m_tag = "R2"; n_cy = cmd_data[0]; end
            4'd3: begin m_tag = "R2"; n_sp = cmd_addr; end
            4'd4: begin m_tag = "R3"; npair(cmd_pair, mpair(cmd_pair) + 16'd1); end
            4'd5: begin m_tag = "R3"; npair(cmd_pair, mpair(cmd_pair) - 16'd1); end
            4'd6: begin
                m_tag = "R4";
                s = {1'b0, mpair(2'd2)} + {1'b0, mpair(cmd_pair)};
                npair(2'd2, s[15:0]); n_cy = s[16];
            end
            4'd7: begin m_tag = "R5"; npair(2'd2, mpair(2'd1)); npair(2'd1, mpair(2'd2)); end
            4'd8: begin
                m_tag = "R6"; a = cmd_addr;
                npair(2'd2, {rref(a + 16'd1), rref(a)});
                mcyc(1'b0, a, 8'h00); mcyc(1'b0, a + 16'd1, 8'h00); midle(); m_cnt = 3;
            end
            4'd9: begin
                m_tag = "R6"; a = cmd_addr;
                mcyc(1'b1, a, m_r[5]); mcyc(1'b1, a + 16'd1, m_r[4]); midle(); m_cnt = 3;
            end
            4'd10: begin
                m_tag = "R7"; a = mpair({1'b0, cmd_pair[0]});
                n_r[7] = rref(a); mcyc(1'b0, a, 8'h00); midle(); m_cnt = 2;
            end
            4'd11: begin
                m_tag = "R7"; a = mpair({1'b0, cmd_pair[0]});
                mcyc(1'b1, a, m_r[7]); midle(); m_cnt = 2;
            end
            4'd12: begin
                m_tag = "R8";
                w = (cmd_pair == 2'd3) ? {m_r[7], 7'd0, m_cy} : mpair(cmd_pair);
                mcyc(1'b1, m_sp - 16'd1, w[15:8]); mcyc(1'b1, m_sp - 16'd2, w[7:0]);
                midle(); n_sp = m_sp - 16'd2; m_cnt = 3;
            end
            4'd13: begin
                m_tag = "R9";
                w = {rref(m_sp + 16'd1), rref(m_sp)};
                if (cmd_pair == 2'd3) begin n_r[7] = w[15:8]; n_cy = w[0]; end
                else npair(cmd_pair, w);
                mcyc(1'b0, m_sp, 8'h00); mcyc(1'b0, m_sp + 16'd1, 8'h00);
                midle(); n_sp = m_sp + 16'd2; m_cnt = 3;
            end
            default: m_tag = "R10";
        endcase
        if (m_cnt == 0) begin m_r = n_r; m_sp = n_sp; m_cy = n_cy; m_done = 1'b1; end
    endtask

    // Reference model advanced on each rising edge from the driven inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_r[i] = '0;
            m_sp = '0; m_cy = 1'b0; m_cnt = 0; m_done = 1'b0;
            exp_q.delete(); started = 1'b1; m_tag = "R1";
        end else begin
            m_done = 1'b0;
            if (m_cnt > 0) begin
                if (cmd_valid) m_tag = "R11";
                m_cnt--;
                if (m_cnt == 0) begin
                    m_r = n_r; m_sp = n_sp; m_cy = n_cy; m_done = 1'b1;
                end
            end else if (cmd_valid) begin
                model_accept();
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        mcyc_t e;
        if (started && !finished) begin
            if (exp_q.size() > 0) e = exp_q.pop_front();
            else begin e.en = 1'b0; e.we = 1'b0; e.addr = '0; e.wd = '0; end
            chk(m_tag, "bc", out_bc, {m_r[0], m_r[1]});
            chk(m_tag, "de", out_de, {m_r[2], m_r[3]});
            chk(m_tag, "hl", out_hl, {m_r[4], m_r[5]});
            chk(m_tag, "acc", {8'h00, out_acc}, {8'h00, m_r[7]});
            chk(m_tag, "sp", out_sp, m_sp);
            chk(m_tag, "cy", {15'd0, out_cy}, {15'd0, m_cy});
            chk("R10", "busy", {15'd0, busy}, {15'd0, (m_cnt > 0)});
            chk("R10", "done", {15'd0, done}, {15'd0, m_done});
            chk("R12", "mem_en", {15'd0, mem_en}, {15'd0, e.en});
            if (e.en) begin
                chk("R12", "mem_we", {15'd0, mem_we}, {15'd0, e.we});
                chk(m_tag, "mem_addr", mem_addr, e.addr);
                if (e.we) chk(m_tag, "mem_wdata", {8'h00, mem_wdata}, {8'h00, e.wd});
            end
        end
    end

    task automatic finish_run();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    endtask

    // Issue one command at the current falling edge and wait until idle
    task automatic issue(input logic [3:0] op, input logic [1:0] pr,
                         input logic [2:0] rg, input logic [7:0] d,
                         input logic [15:0] a);
        cmd_valid = 1'b1; cmd_op = op; cmd_pair = pr; cmd_reg = rg;
        cmd_data = d; cmd_addr = a;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    task automatic wr8(input logic [2:0] rg, input logic [7:0] d);
        issue(4'd1, 2'd0, rg, d, 16'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        $display("FAIL watchdog R10 actual=running expected=finished");
        n_errs++;
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "hl", out_hl, 16'h0000);
        chk("R1", "sp", out_sp, 16'h0000);
        chk("R1", "busy_done_en", {13'd0, busy, done, mem_en}, 16'h0000);

        // R2: byte writes, code 6 ignored
        wr8(3'd0, 8'h56); wr8(3'd1, 8'h78); wr8(3'd2, 8'h9A); wr8(3'd3, 8'hBC);
        wr8(3'd4, 8'h12); wr8(3'd5, 8'h34); wr8(3'd7, 8'h5E); wr8(3'd6, 8'hFF);
        chk("R2", "bc", out_bc, 16'h5678);
        chk("R2", "hl", out_hl, 16'h1234);
        chk("R2", "acc", {8'h00, out_acc}, 16'h005E);

        // R4: pair add, no overflow then overflow
        issue(4'd6, 2'd0, 3'd0, 8'h0, 16'h0);
        chk("R4", "hl", out_hl, 16'h68AC);
        chk("R4", "cy", {15'd0, out_cy}, 16'h0000);
        wr8(3'd4, 8'hF0); wr8(3'd5, 8'h00);
        issue(4'd6, 2'd1, 3'd0, 8'h0, 16'h0);
        chk("R4", "hl", out_hl, 16'h8ABC);
        chk("R4", "cy", {15'd0, out_cy}, 16'h0001);
        chk("R4", "de", out_de, 16'h9ABC);

        // R3: wrap up and down, carry kept
        wr8(3'd4, 8'hFF); wr8(3'd5, 8'hFF);
        issue(4'd4, 2'd2, 3'd0, 8'h0, 16'h0);
        chk("R3", "hl", out_hl, 16'h0000);
        chk("R3", "cy", {15'd0, out_cy}, 16'h0001);
        wr8(3'd0, 8'h00); wr8(3'd1, 8'h00);
        issue(4'd5, 2'd0, 3'd0, 8'h0, 16'h0);
        chk("R3", "bc", out_bc, 16'hFFFF);

        // R5: swap
        issue(4'd7, 2'd0, 3'd0, 8'h0, 16'h0);
        chk("R5", "hl", out_hl, 16'h9ABC);
        chk("R5", "de", out_de, 16'h0000);

        // R2: SP and carry loads
        issue(4'd3, 2'd0, 3'd0, 8'h0, 16'h0100);
        issue(4'd2, 2'd0, 3'd0, 8'h00, 16'h0);
        chk("R2", "sp", out_sp, 16'h0100);
        chk("R2", "cy", {15'd0, out_cy}, 16'h0000);

        // R8: push HL and the accumulator/flag pair
        issue(4'd12, 2'd2, 3'd0, 8'h0, 16'h0);
        chk("R8", "sp", out_sp, 16'h00FE);
        issue(4'd12, 2'd3, 3'd0, 8'h0, 16'h0);
        chk("R8", "sp", out_sp, 16'h00FC);

        // R9: pop into BC and into accumulator/flag
        issue(4'd2, 2'd0, 3'd0, 8'h01, 16'h0);
        wr8(3'd7, 8'h00);
        issue(4'd13, 2'd0, 3'd0, 8'h0, 16'h0);
        chk("R9", "bc", out_bc, 16'h5E00);
        issue(4'd13, 2'd3, 3'd0, 8'h0, 16'h0);
        chk("R9", "acc", {8'h00, out_acc}, 16'h009A);
        chk("R9", "cy", {15'd0, out_cy}, 16'h0000);
        chk("R9", "sp", out_sp, 16'h0100);

        // R6: store at top of memory wraps, load back
        issue(4'd9, 2'd0, 3'd0, 8'h0, 16'hFFFF);
        wr8(3'd4, 8'h00); wr8(3'd5, 8'h00);
        issue(4'd8, 2'd0, 3'd0, 8'h0, 16'hFFFF);
        chk("R6", "hl", out_hl, 16'h9ABC);

        // R7: indirect store through DE, load through BC and DE
        issue(4'd11, 2'd1, 3'd0, 8'h0, 16'h0);
        wr8(3'd0, 8'h00); wr8(3'd1, 8'h00); wr8(3'd7, 8'h11);
        issue(4'd10, 2'd0, 3'd0, 8'h0, 16'h0);
        chk("R7", "acc", {8'h00, out_acc}, 16'h009A);
        issue(4'd5, 2'd1, 3'd0, 8'h0, 16'h0);
        issue(4'd10, 2'd1, 3'd0, 8'h0, 16'h0);
        chk("R7", "acc", {8'h00, out_acc}, 16'h00BC);

        // R11: byte write during a load is dropped
        cmd_valid = 1'b1; cmd_op = 4'd8; cmd_addr = 16'h0200;
        @(negedge clk);
        cmd_op = 4'd1; cmd_reg = 3'd7; cmd_data = 8'h00;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) @(negedge clk);
        chk("R11", "acc", {8'h00, out_acc}, 16'h00BC);
        chk("R11", "hl", out_hl, 16'hA6A7);

        // R10: done with busy low, next command accepted at once
        chk("R10", "done", {15'd0, done}, 16'h0001);
        issue(4'd4, 2'd2, 3'd0, 8'h0, 16'h0);
        chk("R10", "hl", out_hl, 16'hA6A8);

        // R12: port quiet when idle
        @(negedge clk);
        chk("R12", "mem_en", {15'd0, mem_en}, 16'h0000);

        finish_run();
    end

endmodule